// File: doc/BRIEF.md
# MDIO Management Register Bridge

This block gives a host two 16-bit registers through which it reaches the management registers of an Ethernet PHY. The host stages the value to be written in the data register, then writes the command register with the PHY address, the register index, the direction and the start bit. The bridge shifts out a complete management frame on a divided serial clock (MDC) and a bidirectional data line (MDIO). For a read, it captures the 16 bits that the PHY returns.

The start bit reads back as a busy flag for as long as the frame runs. Software polls it. Once it drops, a read result is waiting in the data register. A command that arrives while a frame is in flight is discarded. The serial clock is the system clock divided by a parameter. It rests low whenever the bridge is idle.

Top module: `mdio_mgmt_bridge`

## Requirements
- R1: After a synchronous reset, both host registers read zero, and busy, MDC and the MDIO output enable are all low.
- R2: The command register (host_addr 0) has this layout: bit 0 is start/busy, bit 1 selects the direction (1 write, 0 read), bits 10:6 hold the register index and bits 15:11 hold the PHY address. Only a write with bit 0 set, made while idle, starts a frame and is stored. A write with bit 0 clear starts nothing and changes nothing. Reads of the command register return the stored bits 15:1 with the live busy flag in bit 0.
- R3: Busy reads 1 for exactly 64×DIV clock cycles, counted from the cycle after the accepting write, and then reads 0.
- R4: While busy, MDC is low for DIV/2 cycles and then high for DIV/2 cycles in each bit period, and the first period starts low. MDC is low while idle.
- R5: The frame carries its bits MSB first in this order: 32 ones, start 01, opcode (01 write, 10 read), 5-bit PHY address, 5-bit register index, 2 turnaround bits, 16 data bits.
- R6: MDIO output changes only on the clock edge at which MDC falls. Read data is sampled on the edge at which MDC rises.
- R7: For a write, the 16 data bits come from the data register as it stood when the command was accepted, the turnaround is driven as 1 then 0, and the output enable stays high for all 64 bits.
- R8: For a read, the output enable is low during both turnaround bits and all 16 data bits. When busy clears, the data register holds the 16 sampled bits, with the first-sampled bit as the MSB.
- R9: A command-register write that arrives while busy has no effect. The frame in flight and the stored command bits stay unchanged.
- R10: host_rdata shows the data register when host_addr is 1. The host may write the data register at any time. If that write falls on the edge where a read completes, the read result takes priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 1 | Register select: 0 command, 1 data |
| host_wdata | input | 16 | Host write value |
| host_rdata | output | 16 | Selected register value |
| mdc | output | 1 | Management serial clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench runs writes with a plain value and with alternating 1010 and 0101 data patterns, followed by reads of the same registers. A wrong bit order, a shift that is off by one, or a turnaround placed at the wrong bit shows up as a mismatch at a known bit position. One read targets a PHY address that does not answer. The all-ones result separates captured line values from stale register contents. Two commands test rejection: one written with the start bit clear, and one written in the middle of a running frame. Together with a data write that lands during a read, these separate accepted inputs from ignored ones. On every cycle the bench compares MDC, the enable, the output bit and the busy flag against a behavioural model.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;

    // Stored command word, bits 15:1 of the command register
    typedef struct packed {
        logic [4:0] phy;
        logic [4:0] regn;
        logic [3:0] rsvd;
        logic       wr;
    } mdio_cmd_t;

    localparam logic [1:0] SOF_BITS = 2'b01;

    function automatic logic [1:0] op_bits(input logic wr);
        return wr ? 2'b01 : 2'b10;
    endfunction

    function automatic logic [1:0] ta_bits(input logic wr);
        return wr ? 2'b10 : 2'b11;
    endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt, cnt_nxt;

    always_comb begin
        if (!run || cnt == CW'(DIV - 1))
            cnt_nxt = '0;
        else
            cnt_nxt = cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            cnt <= cnt_nxt;
            mdc <= (cnt_nxt >= CW'(HALF));
        end
    end

    assign rise_stb = run && (cnt == CW'(HALF - 1));
    assign fall_stb = run && (cnt == CW'(DIV - 1));

    // R4
    mdc_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && $rose(mdc)) |-> ($past(cnt) == CW'(HALF - 1)));

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_bridge_pkg::*;
#(
    parameter int PRE_BITS = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  mdio_cmd_t   cmd,
    input  logic [15:0] wdata,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  logic        mdio_i,
    output logic        busy,
    output logic        finish,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rdata
);
    localparam int FRAME    = PRE_BITS + 32;
    localparam int TA_POS   = PRE_BITS + 14;
    localparam int DATA_POS = PRE_BITS + 16;
    localparam int BW       = $clog2(FRAME);

    logic [FRAME-1:0] shreg;
    logic [BW-1:0]    bit_cnt;
    logic             wr_q;
    logic [15:0]      cap;
    logic             last_bit;

    assign last_bit = (bit_cnt == BW'(FRAME - 1));
    assign finish   = busy && fall_stb && last_bit;
    assign mdio_o   = shreg[FRAME-1];
    assign rdata    = cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            bit_cnt <= '0;
            shreg   <= '1;
            mdio_oe <= 1'b0;
            wr_q    <= 1'b0;
            cap     <= '0;
        end else if (start && !busy) begin
            busy    <= 1'b1;
            bit_cnt <= '0;
            wr_q    <= cmd.wr;
            mdio_oe <= 1'b1;
            shreg   <= {{PRE_BITS{1'b1}}, SOF_BITS, op_bits(cmd.wr),
                        cmd.phy, cmd.regn, ta_bits(cmd.wr), wdata};
        end else if (busy) begin
            if (fall_stb) begin
                if (last_bit) begin
                    busy    <= 1'b0;
                    mdio_oe <= 1'b0;
                    shreg   <= '1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                    shreg   <= {shreg[FRAME-2:0], 1'b1};
                    mdio_oe <= wr_q || ((int'(bit_cnt) + 1) < TA_POS);
                end
            end
            if (rise_stb && !wr_q && int'(bit_cnt) >= DATA_POS)
                cap <= {cap[14:0], mdio_i};
        end
    end

    // R8
    ta_release_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !wr_q && int'(bit_cnt) >= TA_POS) |-> !mdio_oe);

    // R7
    wr_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_q) |-> mdio_oe);

endmodule

// File: rtl/mdio_mgmt_bridge.sv
module mdio_mgmt_bridge
    import mdio_bridge_pkg::*;
#(
    parameter int DIV      = 16,
    parameter int PRE_BITS = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_we,
    input  logic        host_addr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int FRAME_CYC = (PRE_BITS + 32) * DIV;
    localparam int KW        = $clog2(FRAME_CYC + 1);

    mdio_cmd_t   cmd_q;
    logic [15:0] data_q;
    logic        busy, finish, start;
    logic        rise_stb, fall_stb;
    logic [15:0] rd_cap;

    assign start = host_we && !host_addr && host_wdata[0] && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            data_q <= '0;
        end else begin
            if (start)
                cmd_q <= mdio_cmd_t'(host_wdata[15:1]);
            if (finish && !cmd_q.wr)
                data_q <= rd_cap;
            else if (host_we && host_addr)
                data_q <= host_wdata;
        end
    end

    assign host_rdata = host_addr ? data_q : {cmd_q, busy};

    mdio_clkdiv #(.DIV(DIV)) u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_seq #(.PRE_BITS(PRE_BITS)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cmd      (mdio_cmd_t'(host_wdata[15:1])),
        .wdata    (data_q),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .finish   (finish),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rdata    (rd_cap)
    );

    // cycle counter for the busy-length check
    logic [KW-1:0] busy_cyc;
    always_ff @(posedge clk) begin
        if (rst || !busy) busy_cyc <= '0;
        else              busy_cyc <= busy_cyc + 1'b1;
    end

    // R3
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_cyc == KW'(FRAME_CYC)));

    // R4
    mdc_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    // R6
    mdio_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));

    // R9
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cmd_q));

endmodule

// File: tb/mdio_mgmt_bridge_tb.sv
module mdio_mgmt_bridge_tb;
    localparam int DIV  = 16;
    localparam int HALF = DIV / 2;
    localparam int FR   = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic        host_addr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int compared = 0;
    int mismatched = 0;

    always #10 clk = ~clk;

    mdio_mgmt_bridge #(.DIV(DIV)) u_dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // behavioural model and PHY responder state
    logic [15:0] phy_regs [32];
    logic        m_busy;
    int          m_k;
    logic [15:1] m_cmd;
    logic [15:0] m_data;
    logic [15:0] m_rd;
    logic [63:0] m_frame;

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 1'b0; m_k = 0; m_cmd = '0; m_data = '0; m_rd = '0; m_frame = '0;
        end else begin
            logic was_busy;
            logic rd_done;
            was_busy = m_busy;
            rd_done  = 1'b0;
            if (m_busy) begin
                if (m_k == FR * DIV - 1) begin
                    m_busy = 1'b0;
                    if (!m_cmd[1]) begin
                        m_data  = m_rd;
                        rd_done = 1'b1;
                    end else if (m_cmd[15:11] == 5'd1) begin
                        phy_regs[m_cmd[10:6]] = m_frame[15:0];
                    end
                end else begin
                    m_k++;
                end
            end
            if (host_we && host_addr && !rd_done)
                m_data = host_wdata;
            if (host_we && !host_addr && host_wdata[0] && !was_busy) begin
                m_busy = 1'b1;
                m_k    = 0;
                m_cmd  = host_wdata[15:1];
                m_rd   = (host_wdata[15:11] == 5'd1) ? phy_regs[host_wdata[10:6]] : 16'hFFFF;
                m_frame = {32'hFFFF_FFFF, 2'b01,
                           host_wdata[1] ? 2'b01 : 2'b10,
                           host_wdata[15:11], host_wdata[10:6],
                           host_wdata[1] ? 2'b10 : 2'b11, m_data};
            end
        end
    end

    // PHY responder: drives read data during the data bits of a read
    always @(negedge clk) begin
        int b;
        b = m_k / DIV;
        if (m_busy && !m_cmd[1] && b >= 48)
            mdio_i <= m_rd[15 - (b - 48)];
        else
            mdio_i <= 1'b1;
    end

    // per-cycle comparison
    always @(posedge clk) begin
        #5;
        if (!rst) begin
            int b;
            logic e_mdc, e_oe;
            b = m_k / DIV;
            e_mdc = m_busy && ((m_k % DIV) >= HALF);
            e_oe  = m_busy && (m_cmd[1] || b < 46);
            check("R3", "busy", {15'd0, host_addr ? m_busy : host_rdata[0]}, {15'd0, m_busy});
            check("R4", "mdc", {15'd0, mdc}, {15'd0, e_mdc});
            check(m_cmd[1] ? "R7" : "R8", "mdio_oe", {15'd0, mdio_oe}, {15'd0, e_oe});
            if (e_oe)
                check("R5", "mdio_o", {15'd0, mdio_o}, {15'd0, m_frame[63 - b]});
            check(host_addr ? "R10" : "R2", "host_rdata", host_rdata,
                  host_addr ? m_data : {m_cmd, m_busy});
        end
    end

    task automatic hwrite(input logic a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0; host_addr = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_busy) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [15:0] mk_cmd(input logic [4:0] phy, input logic [4:0] rg,
                                           input logic wr);
        return {phy, rg, 4'b0, wr, 1'b1};
    endfunction

    task automatic read_check(input string req, input logic [4:0] phy,
                              input logic [4:0] rg, input logic [15:0] exp);
        hwrite(1'b0, mk_cmd(phy, rg, 1'b0));
        wait_idle();
        host_addr = 1'b1;
        #1;
        check(req, "read result", host_rdata, exp);
        host_addr = 1'b0;
    endtask

    task automatic write_reg(input logic [4:0] rg, input logic [15:0] v);
        hwrite(1'b1, v);
        hwrite(1'b0, mk_cmd(5'd1, rg, 1'b1));
        wait_idle();
    endtask

    initial begin
        for (int i = 0; i < 32; i++) phy_regs[i] = 16'(i * 16'h0913 + 16'h1200);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1", "cmd reg", host_rdata, 16'h0000);
        check("R1", "mdc/oe", {14'd0, mdc, mdio_oe}, 16'h0000);
        host_addr = 1'b1;
        #1;
        check("R1", "data reg", host_rdata, 16'h0000);
        host_addr = 1'b0;

        // R7: plain write
        write_reg(5'd4, 16'h0DE1);
        // R8: read back, and read a preloaded register
        read_check("R8", 5'd1, 5'd4, 16'h0DE1);
        read_check("R8", 5'd1, 5'd0, 16'h1200);
        // R8: non-responding PHY returns line idle level
        read_check("R8", 5'd7, 5'd2, 16'hFFFF);
        // alternating patterns
        write_reg(5'd31, 16'hAAAA);
        read_check("R5", 5'd1, 5'd31, 16'hAAAA);
        write_reg(5'd31, 16'h5555);
        read_check("R5", 5'd1, 5'd31, 16'h5555);

        // R2: start bit clear starts nothing
        hwrite(1'b0, 16'hF7C2);
        repeat (4) @(negedge clk);
        check("R2", "no start", host_rdata, {m_cmd, 1'b0});
        check("R2", "mdc idle", {15'd0, mdc}, 16'h0000);

        // R9: command during a running write is ignored
        hwrite(1'b1, 16'h3C3C);
        hwrite(1'b0, mk_cmd(5'd1, 5'd9, 1'b1));
        repeat (100) @(negedge clk);
        hwrite(1'b0, mk_cmd(5'd3, 5'd17, 1'b0));
        #1;
        check("R9", "cmd kept", host_rdata, mk_cmd(5'd1, 5'd9, 1'b1));
        // R10: data write while busy is accepted
        hwrite(1'b1, 16'h9999);
        wait_idle();
        read_check("R9", 5'd1, 5'd9, 16'h3C3C);

        // R10: data write during a read is overwritten by the result
        hwrite(1'b0, mk_cmd(5'd1, 5'd6, 1'b0));
        repeat (50) @(negedge clk);
        hwrite(1'b1, 16'h0101);
        wait_idle();
        host_addr = 1'b1;
        #1;
        check("R10", "read result after data write", host_rdata, phy_regs[6]);
        host_addr = 1'b0;

        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(200000 * 20);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule